// File: doc/BRIEF.md
# Temperature-Sensor Register Slave on a Two-Wire Bus

This block is the bus side of an on-die temperature monitor. It listens on an I2C/SMBus two-wire bus as a slave, recognises its own 7-bit address, keeps an 8-bit register pointer and moves 16-bit words between the bus and a small register file. The register file holds a configuration word, three temperature limits (high, low, critical) and two read-only words: a fixed capabilities word and the live sensor sample. Neighbouring logic reads the configuration and limits from output ports and receives a one-clock pulse when software asks for the event output to be released.

SCL and SDA are oversampled by the system clock through a synchroniser. START, repeated START and STOP are detected while SCL is high. The slave drives SDA only by pulling it low: for ACK bits and for zero data bits during reads. A write transaction carries the address byte, the pointer byte and optionally a data word (high byte first). A read returns the word at the current pointer, high byte first, most significant bit first. It can follow a pointer write after a repeated START.

The protocol controller is one state machine. S_IDLE waits for START. S_ADDR shifts in the address byte and goes to S_ACK_ADDR on a match, or to S_IGNORE otherwise. S_ACK_ADDR goes to S_PTR for a write or to S_RD_HI for a read. S_PTR then goes to S_ACK_PTR, then to S_WR_HI. S_WR_HI goes to S_ACK_HI, then S_WR_LO, then S_ACK_LO, where the word is committed, and then back to S_WR_HI. On reads, S_RD_HI goes to S_MACK_HI, then S_RD_LO, then S_MACK_LO and back to S_RD_HI. A master NACK in either S_MACK state leads to S_IGNORE. START from any state enters S_ADDR. STOP from any state returns to S_IDLE.

Top module: `tsens_i2c_slave`

## Requirements
- R1: The slave acknowledges only address bytes whose upper seven bits equal binary 0011 followed by the 3-bit `dev_sel` input (byte values 0x30..0x3F, bit 0 = 1 for read). It does not pull SDA for any other address, and it stays off the bus until the next START.
- R2: The register pointer is 0x00 after reset. It keeps the last written value across STOP and START. A read that has no pointer byte returns the word at that pointer. Pointer 0x00 reads the `CAPS_WORD` parameter (default 0x0077).
- R3: A write sends the address, then the pointer byte, then optionally a data word with the high byte first. Every byte is acknowledged. The word is written to the register selected by the pointer only after its low byte arrives. A write of the pointer byte alone is valid.
- R4: A read returns the high byte and then the low byte of the selected register, most significant bit first. A read may follow a pointer write through a repeated START. A master NACK ends the read.
- R5: Configuration bit 7 (critical lock) and bit 6 (event lock) can be set by a write. Once set, they stay set until reset.
- R6: While the critical lock is set, writes to the critical limit (pointer 0x04) are ignored. While the event lock is set, writes to the high limit (0x02) and the low limit (0x03) are ignored.
- R7: While either lock is set, the hysteresis field (bits 10:9) and the enable bit (bit 3) keep their values. Shutdown (bit 8) can be cleared but not set. While the event lock is set, the critical-only bit (bit 2) also keeps its value.
- R8: Configuration bits 15:11 and bit 4 read 0. Bit 5 reads 0, and writing 1 to it produces exactly one `event_clear` pulse of one clock. Limit registers keep only bits 12:2; the other bits read 0.
- R9: Writes to read-only pointers (0x00, 0x05, and unmapped pointers) are acknowledged and discarded. Pointer 0x05 reads `sensor_word`.
- R10: A STOP that arrives before the low byte of a data word is complete leaves the target register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | 1 = pull SDA low (open-drain enable) |
| dev_sel | input | 3 | Low three bits of the 7-bit slave address |
| sensor_word | input | 16 | Current temperature sample, read at pointer 0x05 |
| cfg_word | output | 16 | Stored configuration word |
| limit_high | output | 16 | High limit |
| limit_low | output | 16 | Low limit |
| limit_crit | output | 16 | Critical limit |
| event_clear | output | 1 | One-clock pulse when bit 5 is written as 1 |

## Verification
On every cycle, the assertions check the following. Both lock bits are sticky. A locked limit never changes. Shutdown never rises while a lock is held. The clear pulse lasts one clock. The pointer stays still during reads. Each register commit coincides with an acknowledge being driven. The bench scenarios cover what needs whole bus transactions: address rejection, the data word a read returns, repeated START reads, pointer retention, reserved-bit masking, the frozen-field rules under locks, discarding of partial and read-only writes, and the return of the locks to 0 after reset.

// File: rtl/tsens_i2c_pkg.sv
package tsens_i2c_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ACK_ADDR,
        S_PTR,
        S_ACK_PTR,
        S_WR_HI,
        S_ACK_HI,
        S_WR_LO,
        S_ACK_LO,
        S_RD_HI,
        S_MACK_HI,
        S_RD_LO,
        S_MACK_LO,
        S_IGNORE
    } bus_state_t;

    localparam int          BYTE_BITS   = 8;
    localparam logic [7:0]  PTR_CAPS    = 8'h00;
    localparam logic [7:0]  PTR_CFG     = 8'h01;
    localparam logic [7:0]  PTR_LIMIT0  = 8'h02;
    localparam logic [7:0]  PTR_SENSOR  = 8'h05;
    localparam int          N_LIMITS    = 3;
    localparam int          CRIT_SLOT   = 2;

    localparam int          CFG_HYST_HI   = 10;
    localparam int          CFG_HYST_LO   = 9;
    localparam int          CFG_SHDN      = 8;
    localparam int          CFG_CRIT_LOCK = 7;
    localparam int          CFG_EVT_LOCK  = 6;
    localparam int          CFG_CLEAR     = 5;
    localparam int          CFG_ENABLE    = 3;
    localparam int          CFG_CRIT_ONLY = 2;

    localparam logic [15:0] CFG_KEEP_MASK = 16'h07CF;
    localparam logic [15:0] LIMIT_MASK    = 16'h1FFC;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_level,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int LAST = STAGES;
    localparam int CUR  = STAGES - 1;

    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_raw};
        end
    end

    assign sda_level = sda_pipe[CUR];
    assign scl_rise  =  scl_pipe[CUR] & ~scl_pipe[LAST];
    assign scl_fall  = ~scl_pipe[CUR] &  scl_pipe[LAST];
    assign bus_start = scl_pipe[CUR] & scl_pipe[LAST] & sda_pipe[LAST] & ~sda_pipe[CUR];
    assign bus_stop  = scl_pipe[CUR] & scl_pipe[LAST] & ~sda_pipe[LAST] & sda_pipe[CUR];

endmodule

// File: rtl/i2c_word_fsm.sv
module i2c_word_fsm
    import tsens_i2c_pkg::*;
#(
    parameter logic [3:0] DEV_BASE = 4'b0011
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        bus_start,
    input  logic        bus_stop,
    input  logic        sda_level,
    input  logic [2:0]  dev_sel,
    output logic        sda_pull_low,
    output logic [7:0]  reg_addr,
    output logic [15:0] reg_wdata,
    output logic        reg_we,
    input  logic [15:0] reg_rdata
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

    bus_state_t       state_q, state_d;
    logic [CNT_W-1:0] bitcnt_q;
    logic [7:0]       rx_q, tx_q, hi_q, lo_q, ptr_q;
    logic             rw_q;
    logic             byte_done, tx_last, addr_hit, rx_state, tx_state;

    assign byte_done = (bitcnt_q == CNT_FULL);
    assign tx_last   = (bitcnt_q == CNT_LAST);
    assign addr_hit  = (rx_q[7:1] == {DEV_BASE, dev_sel});
    assign rx_state  = (state_q inside {S_ADDR, S_PTR, S_WR_HI, S_WR_LO});
    assign tx_state  = (state_q inside {S_RD_HI, S_RD_LO});
    assign reg_addr  = ptr_q;

    // next state
    always_comb begin
        state_d = state_q;
        if (bus_stop) begin
            state_d = S_IDLE;
        end else if (bus_start) begin
            state_d = S_ADDR;
        end else if (scl_rise) begin
            if ((state_q == S_MACK_HI || state_q == S_MACK_LO) && sda_level)
                state_d = S_IGNORE;
        end else if (scl_fall) begin
            unique case (state_q)
                S_ADDR:     if (byte_done) state_d = addr_hit ? S_ACK_ADDR : S_IGNORE;
                S_ACK_ADDR: state_d = rw_q ? S_RD_HI : S_PTR;
                S_PTR:      if (byte_done) state_d = S_ACK_PTR;
                S_ACK_PTR:  state_d = S_WR_HI;
                S_WR_HI:    if (byte_done) state_d = S_ACK_HI;
                S_ACK_HI:   state_d = S_WR_LO;
                S_WR_LO:    if (byte_done) state_d = S_ACK_LO;
                S_ACK_LO:   state_d = S_WR_HI;
                S_RD_HI:    if (tx_last) state_d = S_MACK_HI;
                S_MACK_HI:  state_d = S_RD_LO;
                S_RD_LO:    if (tx_last) state_d = S_MACK_LO;
                S_MACK_LO:  state_d = S_RD_HI;
                S_IDLE, S_IGNORE: state_d = state_q;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            bitcnt_q  <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            ptr_q     <= PTR_CAPS;
            rw_q      <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            state_q <= state_d;
            reg_we  <= 1'b0;
            if (state_d != state_q) begin
                bitcnt_q <= '0;
            end else if (scl_rise && rx_state && !byte_done) begin
                rx_q     <= {rx_q[6:0], sda_level};
                bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall && tx_state) begin
                tx_q     <= {tx_q[6:0], 1'b0};
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            if (state_q == S_ADDR && state_d == S_ACK_ADDR) rw_q <= rx_q[0];
            if (state_q == S_PTR && state_d == S_ACK_PTR) ptr_q <= rx_q;
            if (state_q == S_WR_HI && state_d == S_ACK_HI) hi_q <= rx_q;
            if (state_q == S_WR_LO && state_d == S_ACK_LO) begin
                reg_we    <= 1'b1;
                reg_wdata <= {hi_q, rx_q};
            end
            if (state_d == S_RD_HI && state_q != S_RD_HI) begin
                tx_q <= reg_rdata[15:8];
                lo_q <= reg_rdata[7:0];
            end
            if (state_d == S_RD_LO && state_q != S_RD_LO) tx_q <= lo_q;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_ACK_ADDR, S_ACK_PTR, S_ACK_HI, S_ACK_LO: sda_pull_low = 1'b1;
            S_RD_HI, S_RD_LO:                         sda_pull_low = ~tx_q[7];
            default:                                  sda_pull_low = 1'b0;
        endcase
    end

    AST_PTR_HOLD_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {S_RD_HI, S_RD_LO, S_MACK_HI, S_MACK_LO}) |=> $stable(ptr_q)); // R2
    AST_WE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (state_q == S_ACK_LO && sda_pull_low)); // R3

endmodule

// File: rtl/tsens_regfile.sv
module tsens_regfile
    import tsens_i2c_pkg::*;
#(
    parameter logic [15:0] CAPS_WORD = 16'h0077
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [7:0]  addr,
    input  logic [15:0] wdata,
    input  logic [15:0] sensor_word,
    output logic [15:0] rdata,
    output logic [15:0] cfg_word,
    output logic [15:0] limit_high,
    output logic [15:0] limit_low,
    output logic [15:0] limit_crit,
    output logic        event_clear
);
    logic [15:0] cfg_q, cfg_d;
    logic        clear_q;
    logic        crit_lock, evt_lock, any_lock;
    logic [15:0] lim_val [N_LIMITS];

    assign crit_lock = cfg_q[CFG_CRIT_LOCK];
    assign evt_lock  = cfg_q[CFG_EVT_LOCK];
    assign any_lock  = crit_lock | evt_lock;

    always_comb begin
        cfg_d = wdata & CFG_KEEP_MASK;
        cfg_d[CFG_CRIT_LOCK] = crit_lock | wdata[CFG_CRIT_LOCK];
        cfg_d[CFG_EVT_LOCK]  = evt_lock  | wdata[CFG_EVT_LOCK];
        if (any_lock) begin
            cfg_d[CFG_HYST_HI:CFG_HYST_LO] = cfg_q[CFG_HYST_HI:CFG_HYST_LO];
            cfg_d[CFG_ENABLE]              = cfg_q[CFG_ENABLE];
            cfg_d[CFG_SHDN]                = cfg_q[CFG_SHDN] & wdata[CFG_SHDN];
        end
        if (evt_lock) cfg_d[CFG_CRIT_ONLY] = cfg_q[CFG_CRIT_ONLY];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            clear_q <= 1'b0;
        end else begin
            clear_q <= we && (addr == PTR_CFG) && wdata[CFG_CLEAR];
            if (we && addr == PTR_CFG) cfg_q <= cfg_d;
        end
    end

    for (genvar g = 0; g < N_LIMITS; g++) begin : g_lim
        logic [15:0] val_q;
        logic        locked;
        assign locked = (g == CRIT_SLOT) ? crit_lock : evt_lock;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= '0;
            else if (we && addr == PTR_LIMIT0 + 8'(g) && !locked)
                val_q <= wdata & LIMIT_MASK;
        end
        assign lim_val[g] = val_q;
    end

    always_comb begin
        rdata = '0;
        if (addr == PTR_CAPS)   rdata = CAPS_WORD;
        if (addr == PTR_CFG)    rdata = cfg_q;
        if (addr == PTR_SENSOR) rdata = sensor_word;
        for (int k = 0; k < N_LIMITS; k++)
            if (addr == PTR_LIMIT0 + 8'(k)) rdata = lim_val[k];
    end

    assign cfg_word    = cfg_q;
    assign limit_high  = lim_val[0];
    assign limit_low   = lim_val[1];
    assign limit_crit  = lim_val[CRIT_SLOT];
    assign event_clear = clear_q;

    AST_CRIT_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        crit_lock |=> crit_lock); // R5
    AST_EVT_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_lock |=> evt_lock); // R5
    AST_CRIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        crit_lock |=> $stable(lim_val[CRIT_SLOT])); // R6
    AST_WINDOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        evt_lock |=> ($stable(lim_val[0]) && $stable(lim_val[1]))); // R6
    AST_SHDN_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (any_lock && !cfg_q[CFG_SHDN]) |=> !cfg_q[CFG_SHDN]); // R7
    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        clear_q |=> !clear_q); // R8

endmodule

// File: rtl/tsens_i2c_slave.sv
module tsens_i2c_slave
    import tsens_i2c_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  DEV_BASE    = 4'b0011,
    parameter logic [15:0] CAPS_WORD   = 16'h0077
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_pull_low,
    input  logic [2:0]  dev_sel,
    input  logic [15:0] sensor_word,
    output logic [15:0] cfg_word,
    output logic [15:0] limit_high,
    output logic [15:0] limit_low,
    output logic [15:0] limit_crit,
    output logic        event_clear
);
    logic        sda_level, scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        reg_we;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .sda_level (sda_level),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_word_fsm #(.DEV_BASE(DEV_BASE)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .bus_start    (bus_start),
        .bus_stop     (bus_stop),
        .sda_level    (sda_level),
        .dev_sel      (dev_sel),
        .sda_pull_low (sda_pull_low),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_we       (reg_we),
        .reg_rdata    (reg_rdata)
    );

    tsens_regfile #(.CAPS_WORD(CAPS_WORD)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .sensor_word (sensor_word),
        .rdata       (reg_rdata),
        .cfg_word    (cfg_word),
        .limit_high  (limit_high),
        .limit_low   (limit_low),
        .limit_crit  (limit_crit),
        .event_clear (event_clear)
    );

endmodule

// File: tb/tsens_i2c_slave_test.sv
module tsens_i2c_slave_test;
    localparam int Q = 6;
    localparam logic [7:0] OWN_W = 8'h3A;
    localparam logic [7:0] OWN_R = 8'h3B;
    localparam logic [15:0] SENSOR = 16'h0C94;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_pull_low, event_clear;
    logic [15:0] cfg_word, limit_high, limit_low, limit_crit;

    int n_chk = 0;
    int n_fail = 0;
    int clr_cnt = 0;
    bit done = 0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] obs_q [$];
    event        obs_ev;

    always #4 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull_low;

    tsens_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_pull_low(sda_pull_low), .dev_sel(3'b101), .sensor_word(SENSOR),
        .cfg_word(cfg_word), .limit_high(limit_high), .limit_low(limit_low),
        .limit_crit(limit_crit), .event_clear(event_clear)
    );

    always @(posedge clk) if (event_clear) clr_cnt <= clr_cnt + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(obs_ev);
            while (obs_q.size() > 0) begin
                logic [15:0] got, want;
                string t;
                got  = obs_q.pop_front();
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                chk(t, got, want);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(2 * Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); b = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_n);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(ack_n);
    endtask

    task automatic get_byte(input logic master_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            logic v;
            get_bit(v);
            b[i] = v;
        end
        put_bit(~master_ack);
    endtask

    task automatic wr_reg(input logic [7:0] ptr, input logic [15:0] w, input string tag);
        logic a0, a1, a2, a3;
        bus_start();
        send_byte(OWN_W, a0); send_byte(ptr, a1);
        send_byte(w[15:8], a2); send_byte(w[7:0], a3);
        bus_stop();
        chk({tag, " acks"}, {a0, a1, a2, a3}, 4'b0000);
    endtask

    task automatic set_ptr(input logic [7:0] ptr, input string tag);
        logic a0, a1;
        bus_start(); send_byte(OWN_W, a0); send_byte(ptr, a1); bus_stop();
        chk({tag, " ptr acks"}, {a0, a1}, 2'b00);
    endtask

    task automatic rd_words(output logic [15:0] w);
        logic [7:0] hb, lb;
        get_byte(1'b1, hb); get_byte(1'b0, lb);
        bus_stop();
        w = {hb, lb};
    endtask

    task automatic rd_cur(input logic [15:0] exp, input string tag);
        logic a0;
        logic [15:0] w;
        bus_start(); send_byte(OWN_R, a0); rd_words(w);
        chk({tag, " addr ack"}, a0, 0);
        exp_q.push_back(exp); tag_q.push_back(tag); obs_q.push_back(w); ->obs_ev;
    endtask

    task automatic rd_rs(input logic [7:0] ptr, input logic [15:0] exp, input string tag);
        logic a0, a1, a2;
        logic [15:0] w;
        bus_start(); send_byte(OWN_W, a0); send_byte(ptr, a1);
        bus_start(); send_byte(OWN_R, a2); rd_words(w);
        chk({tag, " acks"}, {a0, a1, a2}, 3'b000);
        exp_q.push_back(exp); tag_q.push_back(tag); obs_q.push_back(w); ->obs_ev;
    endtask

    initial begin
        logic a;
        tick(5);
        chk("R5 reset cfg", cfg_word, 16'h0000);
        chk("R1 reset sda idle", sda_pull_low, 0);
        rst_n = 1'b1;
        tick(5);
        rd_cur(16'h0077, "R2 reset pointer reads caps");
        // R1 foreign address
        bus_start(); send_byte(8'h30, a); bus_stop();
        chk("R1 foreign address nack", a, 1);
        chk("R1 no drive after nack", sda_pull_low, 0);
        // R3 word write, R4 repeated-start read
        wr_reg(8'h02, 16'h0190, "R3 write high");
        chk("R3 high limit port", limit_high, 16'h0190);
        rd_rs(8'h02, 16'h0190, "R4 repeated start read high");
        // R8 limit masking, R2 pointer-only then plain read
        wr_reg(8'h03, 16'hFFFF, "R8 write low all ones");
        chk("R8 low limit masked", limit_low, 16'h1FFC);
        set_ptr(8'h03, "R3 pointer only");
        rd_cur(16'h1FFC, "R2 pointer held across stop");
        // R10 partial word
        bus_start(); send_byte(OWN_W, a); send_byte(8'h02, a); send_byte(8'h05, a); bus_stop();
        chk("R10 partial write discarded", limit_high, 16'h0190);
        // R9 read-only target
        wr_reg(8'h05, 16'h1234, "R9 write to sensor word");
        rd_rs(8'h05, SENSOR, "R9 sensor word unchanged");
        // R8 config masks and clear pulse
        wr_reg(8'h01, 16'h0728, "R8 config write");
        chk("R8 cfg reserved and clear read 0", cfg_word, 16'h0708);
        rd_rs(8'h01, 16'h0708, "R8 cfg readback");
        chk("R8 one clear pulse", clr_cnt, 1);
        // R5/R7 locks
        wr_reg(8'h01, 16'h0100, "R7 shdn only");
        wr_reg(8'h01, 16'h0140, "R5 set event lock");
        chk("R5 event lock set", cfg_word, 16'h0140);
        wr_reg(8'h01, 16'h0040, "R7 clear shdn");
        chk("R7 shdn clears under lock", cfg_word, 16'h0040);
        wr_reg(8'h01, 16'h070D, "R7 frozen fields");
        chk("R7 hyst enable shdn critonly frozen", cfg_word, 16'h0041);
        wr_reg(8'h01, 16'h0000, "R5 try unlock");
        chk("R5 event lock sticky", cfg_word, 16'h0040);
        // R6 limit protection
        wr_reg(8'h02, 16'h0200, "R6 locked high");
        chk("R6 high ignored", limit_high, 16'h0190);
        wr_reg(8'h04, 16'h0500, "R6 crit open");
        chk("R6 crit written", limit_crit, 16'h0500);
        wr_reg(8'h01, 16'h00C0, "R5 set crit lock");
        wr_reg(8'h04, 16'h0100, "R6 locked crit");
        chk("R6 crit ignored", limit_crit, 16'h0500);
        wr_reg(8'h01, 16'h0000, "R5 try unlock both");
        rd_rs(8'h01, 16'h00C0, "R5 both locks sticky");
        // reset releases locks
        tick(4); rst_n = 1'b0; tick(4);
        chk("R5 reset clears locks", cfg_word, 16'h0000);
        chk("R6 reset clears crit", limit_crit, 16'h0000);
        rst_n = 1'b1; tick(4);
        rd_cur(16'h0077, "R2 pointer back to 0");
        tick(20);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule